// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a single asynchronous serial line into parallel bytes. It runs on the system clock, but it acts only on a sample-enable tick that the surrounding logic supplies at a fixed multiple of the baud rate. Two rates are supported. In the normal rate there are sixteen ticks per bit. In the fast rate there are eight ticks per bit. The serial line passes through a two-flop synchronizer before any decision is made on it.

While idle, the receiver waits for the line to fall. The first low sample counts as sample 1 of a start bit. The start bit is then confirmed by a three-sample majority vote around the bit centre. A start that fails the vote is treated as a noise spike and dropped. A confirmed start restarts the bit-phase counter, so every frame is aligned to its own start edge. The frame then carries eight data bits, least significant first, followed by an optional even parity bit and one stop bit. Each of these bits is resolved by the same centre-sample vote.

When the stop bit has been voted, the block raises a one-cycle strobe. It presents the byte and the two error flags at the same moment. It then returns straight to edge hunting, without waiting for the rest of the stop bit.

Top module: `serial_os_rx`

## Requirements
- R1: After reset, rx_valid, parity_err and frame_err are 0 and rx_byte is 0x00.
- R2: With fast_mode=0 each bit lasts 16 ticks. The first low tick sample after a high one is sample 1 of the start bit. Data bits are received least significant bit first, and the completed byte appears on rx_byte.
- R3: With fast_mode=1 each bit lasts 8 ticks, and frames are received exactly as in R2.
- R4: The start bit is voted on samples 8, 9 and 10 (normal) or 4, 5 and 6 (fast). If two or more of these are high, no frame is reported and the receiver waits for a new falling edge. If two or more are low, the start is accepted.
- R5: Each data, parity and stop bit takes the majority of its samples 8, 9 and 10 (normal) or 4, 5 and 6 (fast). A single inverted sample among them does not change the received bit.
- R6: With par_en=1, an even parity bit follows the data. parity_err is 1 when the XOR of the eight data bits and the parity bit is 1. With par_en=0 there is no parity bit and parity_err is 0.
- R7: A stop bit voted low reports frame_err=1, together with the byte. The receiver is idle straight away, and the next falling edge after the line has gone high again starts a new frame.
- R8: rx_valid is high for exactly one clock cycle per frame. rx_byte, parity_err and frame_err change only in that cycle.
- R9: Bit timing is realigned on every start bit. Frames sent back to back, with no idle time after the stop bit, are each received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Sample enable, one cycle per oversampling period |
| fast_mode | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit; change only while idle |
| par_en | input | 1 | 1: an even parity bit follows the data; change only while idle |
| rxd | input | 1 | Asynchronous serial line, high when idle |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when a frame completes |
| parity_err | output | 1 | Parity mismatch on the last frame |
| frame_err | output | 1 | Stop bit of the last frame was low |

## Verification
The hardest cases are the vote boundaries. A start pulse whose low run ends just before or just after the middle check sample decides between rejecting it and accepting a frame of all ones. A single inverted sample that lands exactly on a centre sample must not change the bit. To reach these cases, the stimulus generates every tick itself and places each line value on a known sample slot. This lets it produce low runs of an exact length and one-sample glitches at chosen positions in both rates.

// File: rtl/rxos_pkg.sv
package rxos_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rxos_sync.sv
module rxos_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rxos_phase.sv
module rxos_phase #(
  parameter int OSR = 16,
  parameter int CW  = $clog2(OSR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fast,
  input  logic          halt,
  output logic [CW-1:0] num,
  output logic          last
);
  localparam logic [CW-1:0] SPAN_N = CW'(OSR);
  localparam logic [CW-1:0] SPAN_F = CW'(OSR / 2);

  logic [CW-1:0] cnt, cnt_n, span;

  assign span = fast ? SPAN_F : SPAN_N;
  // sample number of the sample taken on this tick
  assign num  = (cnt == span) ? CW'(1) : cnt + CW'(1);
  assign last = (num == span);

  always_comb begin
    cnt_n = cnt;
    if (tick) cnt_n = halt ? '0 : num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R2 / R3: the phase never runs past one bit period of the chosen rate
  a_r3_phase_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= span);
endmodule

// File: rtl/rxos_vote.sv
module rxos_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic take,
  input  logic bit_in,
  output logic maj
);
  logic [1:0] ones, ones_n;
  logic [2:0] total;

  assign total = {1'b0, ones} + {2'b00, bit_in};
  assign maj   = (total >= 3'd2);

  always_comb begin
    ones_n = ones;
    if (tick) begin
      if (clr)       ones_n = 2'd0;
      else if (take) ones_n = (total > 3'd3) ? 2'd3 : total[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones <= 2'd0;
    else        ones <= ones_n;
  end

  // R5: the tally is cleared at sample 1, before any vote sample comes in
  a_r5_tally_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr) |=> (ones == 2'd0));
endmodule

// File: rtl/serial_os_rx.sv
module serial_os_rx
  import rxos_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OSR  = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          fast_mode,
  input  logic          par_en,
  input  logic          rxd,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic          parity_err,
  output logic          frame_err
);
  localparam int CW = $clog2(OSR + 1);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LO_N = CW'(OSR / 2);
  localparam logic [CW-1:0] HI_N = CW'(OSR / 2 + 2);
  localparam logic [CW-1:0] LO_F = CW'(OSR / 4);
  localparam logic [CW-1:0] HI_F = CW'(OSR / 4 + 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);

  logic          line;
  logic [CW-1:0] num, lo_pos, hi_pos;
  logic          last, halt, maj, take, clr, decide;

  rx_state_e     state, state_n;
  logic [IW-1:0] idx, idx_n;
  logic [DW-1:0] shreg, shreg_n, byte_n;
  logic          pbit, pbit_n, prev, prev_n;
  logic          valid_n, perr_n, ferr_n;

  rxos_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line));

  rxos_phase #(.OSR(OSR), .CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .fast(fast_mode),
    .halt(halt), .num(num), .last(last));

  assign lo_pos = fast_mode ? LO_F : LO_N;
  assign hi_pos = fast_mode ? HI_F : HI_N;
  assign take   = (num >= lo_pos) && (num <= hi_pos);
  assign clr    = (num == CW'(1));
  assign decide = tick_en && (num == hi_pos);
  assign halt   = (state_n == ST_IDLE);

  rxos_vote u_vote (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .clr(clr),
    .take(take), .bit_in(line), .maj(maj));

  always_comb begin
    state_n = state;
    idx_n   = idx;
    shreg_n = shreg;
    pbit_n  = pbit;
    prev_n  = tick_en ? line : prev;
    valid_n = 1'b0;
    byte_n  = rx_byte;
    perr_n  = parity_err;
    ferr_n  = frame_err;
    if (tick_en) begin
      unique case (state)
        ST_IDLE: if (prev && !line) state_n = ST_START;
        ST_START: begin
          if (decide && maj) state_n = ST_IDLE;
          else if (last) begin
            state_n = ST_DATA;
            idx_n   = '0;
          end
        end
        ST_DATA: begin
          if (decide) shreg_n = {maj, shreg[DW-1:1]};
          if (last) begin
            if (idx == LAST_IDX) state_n = par_en ? ST_PAR : ST_STOP;
            else                 idx_n   = idx + IW'(1);
          end
        end
        ST_PAR: begin
          if (decide) pbit_n = maj;
          if (last)   state_n = ST_STOP;
        end
        ST_STOP: begin
          if (decide) begin
            state_n = ST_IDLE;
            valid_n = 1'b1;
            byte_n  = shreg;
            ferr_n  = !maj;
            perr_n  = par_en && ((^shreg) ^ pbit);
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      prev       <= 1'b1;
      rx_valid   <= 1'b0;
      rx_byte    <= '0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      state      <= state_n;
      idx        <= idx_n;
      shreg      <= shreg_n;
      pbit       <= pbit_n;
      prev       <= prev_n;
      rx_valid   <= valid_n;
      rx_byte    <= byte_n;
      parity_err <= perr_n;
      frame_err  <= ferr_n;
    end
  end

  // R8: the strobe lasts one cycle
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8: a strobe only follows a stop-bit decision
  a_r8_strobe_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(state) == ST_STOP));
  // R7: the framing flag moves only with the strobe
  a_r7_ferr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(frame_err));
  // R6: the parity flag moves only with the strobe
  a_r6_perr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(parity_err));
  // R4: while hunting for an edge, the bit phase stays parked at sample 1
  a_r4_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (num == CW'(1)));
endmodule

// File: tb/tb_serial_os_rx.sv
module tb_serial_os_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       fast_mode = 1'b0;
  logic       par_en = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid, parity_err, frame_err;

  int   n_chk = 0;
  int   n_bad = 0;
  int   vcount = 0;
  int   wide = 0;
  logic last_v = 1'b0;
  logic [7:0] cap_byte = 8'h00;
  logic cap_perr = 1'b0, cap_ferr = 1'b0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  serial_os_rx dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .fast_mode(fast_mode),
    .par_en(par_en), .rxd(rxd), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .parity_err(parity_err), .frame_err(frame_err));

  always @(negedge clk) begin
    if (rx_valid) begin
      vcount   = vcount + 1;
      cap_byte = rx_byte;
      cap_perr = parity_err;
      cap_ferr = frame_err;
      if (last_v) wide = wide + 1;
    end
    last_v = rx_valid;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one oversampling slot: the line value is taken on the tick that closes it
  task automatic slot(input logic v);
    rxd = v;
    repeat (3) @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle_slots(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic send_frame(input string req, input logic [7:0] d, input logic fast,
                            input logic pen, input logic pflip, input logic stopv,
                            input int gbit, input int gpos, input int idle_after);
    logic bits [0:10];
    int   nb, ns, v0;
    logic v;
    fast_mode = fast;
    par_en    = pen;
    ns = fast ? 8 : 16;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[1+i] = d[i];
    nb = 9;
    if (pen) begin
      bits[nb] = (^d) ^ pflip;
      nb++;
    end
    bits[nb] = stopv;
    nb++;
    v0 = vcount;
    for (int k = 0; k < nb; k++)
      for (int s = 1; s <= ns; s++) begin
        v = bits[k];
        if (k == gbit && s == gpos) v = ~v;
        slot(v);
      end
    idle_slots(idle_after);
    chk(req, "frames reported", vcount - v0, 1);
    chk(req, "byte", cap_byte, d);
    chk(req, "parity_err", cap_perr, pen && pflip);
    chk(req, "frame_err", cap_ferr, !stopv);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "rx_byte", rx_byte, 0);
    chk("R1", "parity_err", parity_err, 0);
    chk("R1", "frame_err", frame_err, 0);
    rst_n = 1'b1;
    idle_slots(4);
  endtask

  task automatic t_normal;
    send_frame("R2", 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 4);
    send_frame("R2", 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 4);
    send_frame("R2", 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 4);
  endtask

  task automatic t_fast;
    send_frame("R3", 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, -1, 0, 4);
    send_frame("R3", 8'hD2, 1'b1, 1'b1, 1'b0, 1'b1, -1, 0, 4);
  endtask

  task automatic spike(input string req, input logic fast, input int lows, input int expn,
                       input logic [7:0] expb);
    int v0, ns;
    fast_mode = fast;
    par_en    = 1'b0;
    ns = fast ? 8 : 16;
    v0 = vcount;
    for (int i = 0; i < lows; i++) slot(1'b0);
    idle_slots(11 * ns);
    chk(req, "frames after short low run", vcount - v0, expn);
    if (expn == 1) chk(req, "byte of all-ones frame", cap_byte, expb);
  endtask

  task automatic t_start_vote;
    spike("R4", 1'b0, 8, 0, 8'h00);
    spike("R4", 1'b0, 3, 0, 8'h00);
    spike("R4", 1'b1, 4, 0, 8'h00);
    spike("R4", 1'b0, 9, 1, 8'hFF);
    spike("R4", 1'b1, 5, 1, 8'hFF);
    send_frame("R4", 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 4);
  endtask

  task automatic t_bit_vote;
    send_frame("R5", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4, 9, 4);
    send_frame("R5", 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1, 10, 4);
    send_frame("R5", 8'h96, 1'b1, 1'b0, 1'b0, 1'b1, 3, 5, 4);
    send_frame("R5", 8'h21, 1'b0, 1'b0, 1'b0, 1'b1, 0, 9, 4);
    send_frame("R5", 8'h42, 1'b0, 1'b1, 1'b0, 1'b1, 9, 8, 4);
    send_frame("R5", 8'h77, 1'b1, 1'b0, 1'b0, 1'b1, 9, 6, 4);
  endtask

  task automatic t_parity;
    send_frame("R6", 8'h07, 1'b0, 1'b1, 1'b0, 1'b1, -1, 0, 4);
    send_frame("R6", 8'h07, 1'b0, 1'b1, 1'b1, 1'b1, -1, 0, 4);
    send_frame("R6", 8'hC0, 1'b1, 1'b1, 1'b1, 1'b1, -1, 0, 4);
    send_frame("R6", 8'h07, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 4);
  endtask

  task automatic t_framing;
    send_frame("R7", 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, -1, 0, 2);
    send_frame("R7", 8'h66, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 4);
    send_frame("R7", 8'h18, 1'b1, 1'b1, 1'b0, 1'b0, -1, 0, 1);
    send_frame("R7", 8'hE7, 1'b1, 1'b1, 1'b0, 1'b1, -1, 0, 4);
  endtask

  task automatic t_back_to_back;
    send_frame("R9", 8'h12, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 0);
    send_frame("R9", 8'h34, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 0);
    send_frame("R9", 8'h56, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 3);
    send_frame("R9", 8'hAB, 1'b1, 1'b1, 1'b0, 1'b1, -1, 0, 0);
    send_frame("R9", 8'hCD, 1'b1, 1'b1, 1'b0, 1'b1, -1, 0, 5);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_fast();
    t_start_vote();
    t_bit_vote();
    t_parity();
    t_framing();
    t_back_to_back();
    chk("R8", "strobes longer than one cycle", wide, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule